// File: doc/BRIEF.md
# Buffered SPI Target Port

This block is the target (slave) end of an SPI link, clocked entirely by the system bus clock. The serial clock, select and data-in pins pass through two-flop synchronisers before the block looks for edges on them, so the bus clock must run at least four times faster than the serial clock. Each transfer moves an 8-bit frame in both directions at once, most significant bit first. Two mode inputs choose the clock polarity and the clock phase. Polarity only sets which serial clock level counts as idle. Phase decides which edge presents data and which edge samples it, and also decides what starts a transfer.

A host on the bus side writes the next outgoing byte into a one-byte holding buffer. The buffer is copied into the transmit register only when a transfer starts. A byte that arrives too late stays in the buffer for the following transfer. If no new byte is pending, the last byte is sent again. Each completed incoming byte lands in a receive register and raises a full flag until the host reads it. A one-cycle done pulse marks each completion. The serial data output is only meant to be driven while the port is enabled and selected, and an output-enable signal says when.

Top module: `spi_slave_buf`

## Requirements
- R1: `cpol` and `cpha` select four clock formats. The normalised clock is the serial clock XOR `cpol`, so the idle level equals `cpol`. In every format the frame is 8 bits, sent and received most significant bit first.
- R2: With `cpha`=0, a transfer starts when the synchronised select falls. The first bit is on `miso_o` before the first clock edge. Bits are sampled on leading edges and the next bit is presented on trailing edges. Clock edges after the eighth sample, while select stays low, start nothing new.
- R3: With `cpha`=1, a transfer starts at the first leading edge while selected and idle. Bits are presented on leading edges and sampled on trailing edges. Select may stay low between consecutive bytes.
- R4: The byte shifted out equals the byte loaded from the buffer, and the byte received equals the bits seen on `mosi_i`.
- R5: A host write captured on a clock edge before the edge on which the transfer starts is sent in that transfer. A write captured on the start edge, or during the transfer, is held and sent in the next transfer.
- R6: When no write is pending at the start of a transfer, the previously loaded byte is sent again.
- R7: When the eighth bit is sampled, `rx_data` takes the received byte and `rx_full` is set. `done` is high for exactly one cycle at the same time.
- R8: `rx_rd` clears `rx_full`, but a completion in the same cycle keeps the flag set.
- R9: `miso_oe` is high only while `en` is high and the synchronised select is low.
- R10: After `en` rises, serial clock edges are ignored until the clock has been seen at its idle level.
- R11: If select rises before the eighth sample, the transfer is abandoned with no `done`. The next transfer starts again from bit 7.
- R12: While `en` is low, no transfer starts and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| sck_i | input | 1 | Serial clock pin (asynchronous) |
| ss_n_i | input | 1 | Active-low select pin (asynchronous) |
| mosi_i | input | 1 | Serial data in (asynchronous) |
| tx_wr | input | 1 | Host write strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to send |
| rx_rd | input | 1 | Host read strobe, clears the full flag |
| miso_o | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for serial data out |
| rx_data | output | DATA_W | Last received byte |
| rx_full | output | 1 | Receive register holds an unread byte |
| done | output | 1 | One-cycle pulse per completed byte |

## Verification
The case that needs care is a host write that lands on the same bus cycle in which a transfer starts. The bench lowers select on a known clock phase. It then counts the two synchroniser stages and the edge register to find the start edge, and places the write strobe on that edge in one run and one cycle earlier in another. The late write must leave the old byte on the wire and appear in the following transfer. The early write must go out at once. A write placed in the middle of a transfer is judged the same way as the late one.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

  typedef struct packed {
    logic lead;
    logic trail;
  } sck_ev_t;

  // edge on which MOSI is sampled
  function automatic logic sample_pick(input logic cpha, input sck_ev_t e);
    return cpha ? e.trail : e.lead;
  endfunction

  // edge on which the next MISO bit is presented
  function automatic logic shift_pick(input logic cpha, input sck_ev_t e);
    return cpha ? e.lead : e.trail;
  endfunction

  // event that opens a transfer
  function automatic logic start_pick(input logic cpha, input sck_ev_t e, input logic ss_fall);
    return cpha ? e.lead : ss_fall;
  endfunction

endpackage

// File: rtl/ssb_sync.sv
module ssb_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= RST_VAL[g];
        stab <= RST_VAL[g];
      end else begin
        meta <= d[g];
        stab <= meta;
      end
    end
    assign q[g] = stab;
  end
endmodule

// File: rtl/ssb_edge.sv
module ssb_edge
  import ssb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    cpol,
  input  logic    sck_s,
  output sck_ev_t ev
);
  logic ck, ck_d, armed;
  assign ck = sck_s ^ cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_d  <= 1'b0;
      armed <= 1'b0;
    end else begin
      ck_d  <= ck;
      armed <= en & (armed | ~ck);
    end
  end

  assign ev.lead  = en & armed & ck & ~ck_d;
  assign ev.trail = en & armed & ~ck & ck_d;
endmodule

// File: rtl/ssb_tx.sv
module ssb_tx #(
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              start,
  input  logic              shift,
  output logic              load,
  output logic              pend,
  output logic              miso
);
  logic [DATA_W-1:0] hold_q, sr_q, view;
  logic [CW-1:0]     idx_q;

  assign load = start & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend   <= 1'b0;
      sr_q   <= '0;
      idx_q  <= '0;
    end else begin
      if (tx_wr) hold_q <= tx_data;
      if (tx_wr) pend <= 1'b1;
      else if (load) pend <= 1'b0;
      if (load) sr_q <= hold_q;
      if (start) idx_q <= '0;
      else if (shift) idx_q <= idx_q + CW'(1);
    end
  end

  assign view = sr_q << idx_q;
  assign miso = view[DATA_W-1];
endmodule

// File: rtl/ssb_rx.sv
module ssb_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              bit_in,
  input  logic              fin,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              done
);
  logic [DATA_W-1:0] sr_q, nxt;
  assign nxt = {sr_q[DATA_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (sample) sr_q <= nxt;
      if (fin) rx_data <= nxt;
      done <= fin;
      if (fin) rx_full <= 1'b1;
      else if (rx_rd) rx_full <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf
  import ssb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic              miso_o,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              done
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic sck_s, ss_n_s, mosi_s, ss_d;
  sck_ev_t ev;

  ssb_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, ss_n_i, mosi_i}),
    .q({sck_s, ss_n_s, mosi_s})
  );

  ssb_edge u_edge (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .sck_s(sck_s), .ev(ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_d <= 1'b1;
    else        ss_d <= ss_n_s;
  end

  // named internal events
  logic selected, ss_fall, start_ev, sample_ev, shift_ev, done_ev, abort_ev;
  logic active, load_ev, tx_pend;
  logic [CW-1:0] cnt_q;

  assign selected  = en & ~ss_n_s;
  assign ss_fall   = en & ss_d & ~ss_n_s;
  assign start_ev  = ~active & selected & start_pick(cpha, ev, ss_fall);
  assign sample_ev = active & selected & sample_pick(cpha, ev);
  assign shift_ev  = active & selected & shift_pick(cpha, ev);
  assign done_ev   = sample_ev & (cnt_q == LAST);
  assign abort_ev  = active & ~selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (start_ev) active <= 1'b1;
      else if (done_ev | abort_ev) active <= 1'b0;
      if (start_ev | done_ev) cnt_q <= '0;
      else if (sample_ev) cnt_q <= cnt_q + CW'(1);
    end
  end

  ssb_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
    .start(start_ev), .shift(shift_ev), .load(load_ev), .pend(tx_pend),
    .miso(miso_o)
  );

  ssb_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample_ev), .bit_in(mosi_s),
    .fin(done_ev), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .done(done)
  );

  assign miso_oe = selected;
endmodule

// File: rtl/ssb_chk.sv
module ssb_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tx_wr,
  input logic rx_rd,
  input logic rx_full,
  input logic done,
  input logic miso_oe,
  input logic start_ev,
  input logic load_ev,
  input logic tx_pend,
  input logic active,
  input logic ss_n_s
);
  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> rx_full);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(active));
  // R8
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(rx_full) |-> $past(rx_rd));
  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) miso_oe |-> en);
  // R5
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (tx_wr && start_ev) |=> tx_pend);
  // R5
  load_when_chk: assert property (@(posedge clk) disable iff (!rst_n) load_ev |-> start_ev);
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n) (active && ss_n_s) |=> !active);
  // R12
  off_chk: assert property (@(posedge clk) disable iff (!rst_n) (active && !en) |=> !active);
endmodule

bind spi_slave_buf ssb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_wr(tx_wr), .rx_rd(rx_rd),
  .rx_full(rx_full), .done(done), .miso_oe(miso_oe), .start_ev(start_ev),
  .load_ev(load_ev), .tx_pend(tx_pend), .active(active), .ss_n_s(ss_n_s)
);

// File: tb/spi_slave_buf_tb.sv
module spi_slave_buf_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, en, cpol, cpha, sck, ss_n, mosi, tx_wr, rx_rd;
  logic [7:0] tx_data;
  logic miso, miso_oe, rx_full, done;
  logic [7:0] rx_data;

  int total = 0, bad = 0, done_cnt = 0;
  bit finished = 1'b0;

  spi_slave_buf u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cpha(cpha),
    .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .miso_o(miso), .miso_oe(miso_oe),
    .rx_data(rx_data), .rx_full(rx_full), .done(done)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wr_after(input int n, input logic [7:0] d);
    repeat (n) @(negedge clk);
    tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic set_mode(input logic pol, input logic pha);
    @(negedge clk); en = 1'b0; ss_n = 1'b1;
    wait_n(2);
    cpol = pol; cpha = pha; sck = pol;
    wait_n(6); en = 1'b1; wait_n(6);
  endtask

  task automatic xfer(input logic [7:0] mo, input bit sb, input bit se, input int nb,
                      output logic [7:0] got, output bit oe_all, output bit oe_any);
    got = '0; oe_all = 1'b1; oe_any = 1'b0;
    if (sb) begin @(negedge clk); ss_n = 1'b0; wait_n(H); end
    for (int i = 0; i < nb; i++) begin
      if (!cpha) begin
        mosi = mo[7-i]; wait_n(H);
        sck = ~cpol; got[7-i] = miso;
        oe_all &= miso_oe; oe_any |= miso_oe;
        wait_n(H); sck = cpol;
      end else begin
        sck = ~cpol; mosi = mo[7-i]; wait_n(H);
        sck = cpol; got[7-i] = miso;
        oe_all &= miso_oe; oe_any |= miso_oe;
        wait_n(H);
      end
    end
    if (se) begin wait_n(H); ss_n = 1'b1; wait_n(H); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, t, r, last_t;
    bit oa, ob;
    int dc;
    rst_n = 1'b0; en = 1'b0; cpol = 1'b0; cpha = 1'b0; sck = 1'b0;
    ss_n = 1'b1; mosi = 1'b0; tx_wr = 1'b0; rx_rd = 1'b0; tx_data = '0;
    wait_n(5); rst_n = 1'b1; wait_n(2);
    chk("R9 reset oe", int'(miso_oe), 0);
    chk("R7 reset full", int'(rx_full), 0);
    chk("R7 reset done", int'(done), 0);

    // R1 R4: all four formats, several patterns each
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      last_t = '0;
      for (int p = 0; p < 4; p++) begin
        t = (p == 0) ? 8'hFF : 8'(m * 53 + p * 91 + 7);
        r = ~t ^ 8'(p * 16 + m);
        host_write(t);
        dc = done_cnt;
        xfer(r, 1'b1, 1'b1, 8, got, oa, ob);
        chk($sformatf("R1/R4 miso mode%0d", m), int'(got), int'(t));
        chk($sformatf("R4 rx mode%0d", m), int'(rx_data), int'(r));
        chk("R7 full set", int'(rx_full), 1);
        chk("R7 one done", done_cnt, dc + 1);
        chk("R9 oe while selected", int'(oa), 1);
        chk("R9 oe after deselect", int'(miso_oe), 0);
        host_read();
        chk("R8 read clears", int'(rx_full), 0);
        last_t = t;
      end
      xfer(8'h00, 1'b1, 1'b1, 8, got, oa, ob);
      chk($sformatf("R6 resend mode%0d", m), int'(got), int'(last_t));
    end

    // R5: write placement around the start edge (phase 0)
    set_mode(1'b0, 1'b0);
    host_write(8'h5A);
    xfer(8'h11, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R5 base", int'(got), 'h5A);
    fork wr_after(3, 8'hC3); join_none
    xfer(8'h22, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R5 write on start edge", int'(got), 'h5A);
    xfer(8'h33, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R5 held byte sent next", int'(got), 'hC3);
    fork wr_after(2, 8'h96); join_none
    xfer(8'h44, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R5 write one cycle early", int'(got), 'h96);
    fork wr_after(40, 8'h69); join_none
    xfer(8'h55, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R5 mid write not used", int'(got), 'h96);
    xfer(8'h66, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R5 mid write sent next", int'(got), 'h69);

    // R2: phase 0 needs a new select fall
    host_read();
    dc = done_cnt;
    xfer(8'h81, 1'b1, 1'b0, 8, got, oa, ob);
    xfer(8'h18, 1'b0, 1'b1, 8, got, oa, ob);
    chk("R2 no restart without select", done_cnt, dc + 1);
    chk("R2 rx kept", int'(rx_data), 'h81);

    // R3: phase 1 back to back with select held low
    set_mode(1'b0, 1'b1);
    host_read();
    host_write(8'hE1);
    dc = done_cnt;
    xfer(8'h12, 1'b1, 1'b0, 8, got, oa, ob);
    chk("R3 first byte out", int'(got), 'hE1);
    chk("R3 first byte in", int'(rx_data), 'h12);
    host_write(8'h7E);
    xfer(8'h34, 1'b0, 1'b1, 8, got, oa, ob);
    chk("R3 second byte out", int'(got), 'h7E);
    chk("R3 second byte in", int'(rx_data), 'h34);
    chk("R3 two completions", done_cnt, dc + 2);

    // R11: abandon after four bits
    set_mode(1'b1, 1'b0);
    host_read();
    dc = done_cnt;
    xfer(8'hF0, 1'b1, 1'b1, 4, got, oa, ob);
    chk("R11 no done", done_cnt, dc);
    chk("R11 no full", int'(rx_full), 0);
    host_write(8'h3A);
    xfer(8'hA3, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R11 restart out", int'(got), 'h3A);
    chk("R11 restart in", int'(rx_data), 'hA3);

    // R10: enable while clock sits at its active level
    @(negedge clk); en = 1'b0; ss_n = 1'b1;
    wait_n(2);
    cpol = 1'b0; cpha = 1'b0; sck = 1'b1;
    wait_n(6); en = 1'b1; wait_n(6);
    host_write(8'hB4);
    @(negedge clk); ss_n = 1'b0; wait_n(H);
    sck = 1'b0; wait_n(H);
    xfer(8'h4B, 1'b0, 1'b1, 8, got, oa, ob);
    chk("R10 false edge ignored out", int'(got), 'hB4);
    chk("R10 false edge ignored in", int'(rx_data), 'h4B);

    // R12: disabled port
    host_read();
    @(negedge clk); en = 1'b0; wait_n(4);
    dc = done_cnt;
    xfer(8'h55, 1'b1, 1'b1, 8, got, oa, ob);
    chk("R12 no done", done_cnt, dc);
    chk("R12 no full", int'(rx_full), 0);
    chk("R12/R9 oe low", int'(ob), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule